// File: doc/BRIEF.md
# Indexed Register Bank Port

This block is the host-facing front end of a display controller's configuration space. The host sees a byte-wide, memory-mapped window with an address, write data, read data and separate read and write strobes. Behind that window sit six banks of 8-bit configuration registers. Each bank is reached through an index latch that picks one register and a data port that reads or writes that register. The block also holds a directly written miscellaneous output register, and it passes an external input status byte back to the host.

Five of the banks use two neighbouring addresses: the index port, and the data port one byte above it. The sixth bank, the attribute bank, has a single write address. A phase flip-flop decides whether each write to that address loads the index or stores the selected register. A read of the status address returns the phase to index. This gives software a known starting point without knowing how many attribute writes came before.

Every register byte is exported as one flat vector so that downstream video logic can use the settings directly. Bit 5 of the attribute index also appears as a separate video-enable output.

Top module: `idx_regbank_port`

## Requirements
- R1: While `rst` is high on a clock edge, every index latch, every bank register and the miscellaneous register clear to 0x00, the attribute phase returns to index, and `host_rdata` clears to 0x00.
- R2: The index/data address pairs are extension bank 0x7AC/0x7AD, panel bank 0x7A0/0x7A1, CRT bank 0x7A8/0x7A9, graphics bank 0x79C/0x79D and sequencer bank 0x788/0x789. A write to an index port latches the byte as that bank's index. A write to a data port stores the byte in the register that the bank's current index selects. Other banks are not affected.
- R3: `host_rdata` is registered. It loads on a clock edge where `host_rd` is high and holds its value on every other edge. An index port returns the last index written to it, and a data port returns the register its bank's index selects.
- R4: Writes to 0x780 alternate between two phases, starting in the index phase. An index-phase write latches the attribute index and moves to the data phase. A data-phase write stores the byte in the selected attribute register and moves back to the index phase.
- R5: A read of 0x7B4 returns `status_in` as sampled on that edge, and it forces the attribute phase back to index.
- R6: `video_en` equals bit 5 (mask 0x20) of the attribute index latch.
- R7: A read of 0x780 returns the attribute index, and a read of 0x781 returns the selected attribute register. Neither read changes the attribute phase.
- R8: The miscellaneous register at 0x784 loads directly from a write to that address, drives `misc_out`, and reads back at the same address.
- R9: Byte i of bank b appears on `regs_flat[(b*256+i)*8 +: 8]`. The bank numbers are extension 0, panel 1, CRT 2, graphics 3, sequencer 4 and attribute 5.
- R10: Writes to unmapped addresses, and to the read-only addresses 0x781 and 0x7B4, change no state. Reads of unmapped addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 12 | Byte offset within the register window |
| host_wdata | input | 8 | Write data byte |
| host_wr | input | 1 | Write strobe, one access per cycle |
| host_rd | input | 1 | Read strobe, one access per cycle |
| host_rdata | output | 8 | Registered read data |
| status_in | input | 8 | Input status byte returned at 0x7B4 |
| misc_out | output | 8 | Miscellaneous output register |
| video_en | output | 1 | Bit 5 of the attribute index |
| regs_flat | output | 12288 | All bank registers, bank 0 in the least significant bits |

## Verification
Directed sequences first give each paired bank an index and a data value of its own, then read both back. This separates a crossed bank decode from a swapped index and data port. The attribute port is written an odd number of times, then the status register is read, then the port is written again. The final index readback shows whether the status read actually reset the phase, or whether the toggle only happened to line up. After that, long random streams of mixed reads, writes and idle cycles, over mapped and unmapped addresses, are compared each clock against a behavioural model. That model covers the whole exported register image, so a write that lands in the wrong register or in a second register is exposed.

// File: rtl/irb_pkg.sv
package irb_pkg;

    localparam int ADDR_W        = 12;
    localparam int DW            = 8;
    localparam int NUM_IDX_BANKS = 5;
    localparam int NUM_BANKS     = NUM_IDX_BANKS + 1;
    localparam int ATTR_BANK     = NUM_IDX_BANKS;
    localparam int BANK_SEL_W    = $clog2(NUM_BANKS);

    localparam logic [ADDR_W-1:0] ATTR_PORT    = 12'h780;
    localparam logic [ADDR_W-1:0] ATTR_RD_PORT = 12'h781;
    localparam logic [ADDR_W-1:0] MISC_PORT    = 12'h784;
    localparam logic [ADDR_W-1:0] STAT_PORT    = 12'h7B4;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_IDX,
        ACC_DAT,
        ACC_ATTR,
        ACC_ATTR_RD,
        ACC_MISC,
        ACC_STAT
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e               kind;
        logic [BANK_SEL_W-1:0]   bank;
    } acc_t;

    typedef enum logic {
        PH_INDEX = 1'b0,
        PH_DATA  = 1'b1
    } phase_e;

    // index port of a paired bank; its data port sits one byte above
    function automatic logic [ADDR_W-1:0] index_port(input int b);
        case (b)
            0:       index_port = 12'h7AC;
            1:       index_port = 12'h7A0;
            2:       index_port = 12'h7A8;
            3:       index_port = 12'h79C;
            default: index_port = 12'h788;
        endcase
    endfunction

    function automatic acc_t decode_addr(input logic [ADDR_W-1:0] a);
        acc_t r;
        r.kind = ACC_NONE;
        r.bank = '0;
        for (int b = 0; b < NUM_IDX_BANKS; b++) begin
            if (a == index_port(b)) begin
                r.kind = ACC_IDX;
                r.bank = BANK_SEL_W'(b);
            end else if (a == index_port(b) + ADDR_W'(1)) begin
                r.kind = ACC_DAT;
                r.bank = BANK_SEL_W'(b);
            end
        end
        if (a == ATTR_PORT)    r.kind = ACC_ATTR;
        if (a == ATTR_RD_PORT) r.kind = ACC_ATTR_RD;
        if (a == MISC_PORT)    r.kind = ACC_MISC;
        if (a == STAT_PORT)    r.kind = ACC_STAT;
        return r;
    endfunction

endpackage

// File: rtl/irb_bank.sv
module irb_bank
    import irb_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                idx_we,
    input  logic                dat_we,
    input  logic [DW-1:0]       wdata,
    output logic [DW-1:0]       idx_q,
    output logic [DW-1:0]       dat_q,
    output logic [DEPTH*DW-1:0] flat
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [DW-1:0]    mem [DEPTH];
    logic [IDX_W-1:0] sel;

    assign sel   = idx_q[IDX_W-1:0];
    assign dat_q = mem[sel];

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (idx_we) begin
            idx_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (dat_we) begin
            mem[sel] <= wdata;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_flat
        assign flat[i*DW +: DW] = mem[i];
    end

endmodule

// File: rtl/irb_attr_ctl.sv
module irb_attr_ctl
    import irb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   attr_wr,
    input  logic   stat_rd,
    output phase_e phase,
    output logic   idx_we,
    output logic   dat_we
);
    assign idx_we = attr_wr && (phase == PH_INDEX);
    assign dat_we = attr_wr && (phase == PH_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_INDEX;
        end else if (stat_rd) begin
            phase <= PH_INDEX;
        end else if (attr_wr) begin
            phase <= (phase == PH_INDEX) ? PH_DATA : PH_INDEX;
        end
    end

endmodule

// File: rtl/irb_rdmux.sv
module irb_rdmux
    import irb_pkg::*;
(
    input  acc_t                          acc,
    input  logic [NUM_BANKS-1:0][DW-1:0]  idx_all,
    input  logic [NUM_BANKS-1:0][DW-1:0]  dat_all,
    input  logic [DW-1:0]                 misc,
    input  logic [DW-1:0]                 status,
    output logic [DW-1:0]                 rd_val
);
    logic bank_ok;
    assign bank_ok = (int'(acc.bank) < NUM_BANKS);

    always_comb begin
        rd_val = '0;
        case (acc.kind)
            ACC_IDX:     if (bank_ok) rd_val = idx_all[acc.bank];
            ACC_DAT:     if (bank_ok) rd_val = dat_all[acc.bank];
            ACC_ATTR:    rd_val = idx_all[ATTR_BANK];
            ACC_ATTR_RD: rd_val = dat_all[ATTR_BANK];
            ACC_MISC:    rd_val = misc;
            ACC_STAT:    rd_val = status;
            default:     rd_val = '0;
        endcase
    end

endmodule

// File: rtl/idx_regbank_port.sv
module idx_regbank_port
    import irb_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [ADDR_W-1:0]             host_addr,
    input  logic [DW-1:0]                 host_wdata,
    input  logic                          host_wr,
    input  logic                          host_rd,
    output logic [DW-1:0]                 host_rdata,
    input  logic [DW-1:0]                 status_in,
    output logic [DW-1:0]                 misc_out,
    output logic                          video_en,
    output logic [NUM_BANKS*DEPTH*DW-1:0] regs_flat
);
    localparam int BANK_BITS = DEPTH * DW;
    localparam int VEN_BIT   = 5;

    acc_t                              acc;
    logic [NUM_BANKS-1:0][DW-1:0]      idx_all;
    logic [NUM_BANKS-1:0][DW-1:0]      dat_all;
    logic [NUM_BANKS-1:0][BANK_BITS-1:0] flat_all;
    logic [DW-1:0]                     rd_val;
    phase_e                            attr_ph;
    logic                              attr_idx_we;
    logic                              attr_dat_we;

    assign acc = decode_addr(host_addr);

    for (genvar b = 0; b < NUM_IDX_BANKS; b++) begin : g_pair
        logic iwe, dwe;
        assign iwe = host_wr && (acc.kind == ACC_IDX) && (acc.bank == BANK_SEL_W'(b));
        assign dwe = host_wr && (acc.kind == ACC_DAT) && (acc.bank == BANK_SEL_W'(b));
        irb_bank #(.DEPTH(DEPTH)) bank_i (
            .clk    (clk),
            .rst    (rst),
            .idx_we (iwe),
            .dat_we (dwe),
            .wdata  (host_wdata),
            .idx_q  (idx_all[b]),
            .dat_q  (dat_all[b]),
            .flat   (flat_all[b])
        );
    end

    irb_attr_ctl attr_ctl_i (
        .clk     (clk),
        .rst     (rst),
        .attr_wr (host_wr && (acc.kind == ACC_ATTR)),
        .stat_rd (host_rd && (acc.kind == ACC_STAT)),
        .phase   (attr_ph),
        .idx_we  (attr_idx_we),
        .dat_we  (attr_dat_we)
    );

    irb_bank #(.DEPTH(DEPTH)) attr_bank_i (
        .clk    (clk),
        .rst    (rst),
        .idx_we (attr_idx_we),
        .dat_we (attr_dat_we),
        .wdata  (host_wdata),
        .idx_q  (idx_all[ATTR_BANK]),
        .dat_q  (dat_all[ATTR_BANK]),
        .flat   (flat_all[ATTR_BANK])
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            misc_out <= '0;
        end else if (host_wr && (acc.kind == ACC_MISC)) begin
            misc_out <= host_wdata;
        end
    end

    irb_rdmux rdmux_i (
        .acc     (acc),
        .idx_all (idx_all),
        .dat_all (dat_all),
        .misc    (misc_out),
        .status  (status_in),
        .rd_val  (rd_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rdata <= '0;
        end else if (host_rd) begin
            host_rdata <= rd_val;
        end
    end

    assign video_en  = idx_all[ATTR_BANK][VEN_BIT];
    assign regs_flat = flat_all;

endmodule

// File: rtl/idx_regbank_port_chk.sv
module idx_regbank_port_chk
    import irb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] host_addr,
    input logic [DW-1:0]     host_wdata,
    input logic              host_wr,
    input logic              host_rd,
    input logic [DW-1:0]     host_rdata,
    input logic [DW-1:0]     status_in,
    input logic [DW-1:0]     misc_out,
    input logic              video_en,
    input logic              attr_phase
);
    // R4
    attr_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !host_rd && host_addr == ATTR_PORT && !attr_phase) |=> attr_phase);

    // R4
    attr_return_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !host_rd && host_addr == ATTR_PORT && attr_phase) |=> !attr_phase);

    // R5
    status_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_addr == STAT_PORT) |=> !attr_phase);

    // R5
    status_data_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_addr == STAT_PORT) |=> (host_rdata == $past(status_in)));

    // R8
    misc_load_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == MISC_PORT) |=> (misc_out == $past(host_wdata)));

    // R3
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !host_rd |=> $stable(host_rdata));

    // R6
    video_on_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(video_en) |-> $past(host_wr && host_addr == ATTR_PORT && !attr_phase && host_wdata[5]));

endmodule

bind idx_regbank_port idx_regbank_port_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_rdata (host_rdata),
    .status_in  (status_in),
    .misc_out   (misc_out),
    .video_en   (video_en),
    .attr_phase (attr_ph)
);

// File: tb/idx_regbank_port_tb_top.sv
module idx_regbank_port_tb_top;

    localparam int DEPTH = 256;
    localparam int NB    = 6;
    localparam int FLAT  = NB * DEPTH * 8;

    logic             clk = 1'b0;
    logic             rst;
    logic [11:0]      host_addr;
    logic [7:0]       host_wdata;
    logic             host_wr;
    logic             host_rd;
    logic [7:0]       host_rdata;
    logic [7:0]       status_in;
    logic [7:0]       misc_out;
    logic             video_en;
    logic [FLAT-1:0]  regs_flat;

    always #2 clk = ~clk;

    idx_regbank_port #(.DEPTH(DEPTH)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_rdata (host_rdata),
        .status_in  (status_in),
        .misc_out   (misc_out),
        .video_en   (video_en),
        .regs_flat  (regs_flat)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // reference model state
    logic [7:0] m_idx [NB];
    logic [7:0] m_reg [NB][DEPTH];
    bit         m_ph;
    logic [7:0] m_misc;
    logic [7:0] m_rd;

    logic [11:0] pair_base [5] = '{12'h7AC, 12'h7A0, 12'h7A8, 12'h79C, 12'h788};

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] m_read(input logic [11:0] a, input logic [7:0] st);
        for (int b = 0; b < 5; b++) begin
            if (a == pair_base[b])      return m_idx[b];
            if (a == pair_base[b] + 1)  return m_reg[b][m_idx[b]];
        end
        case (a)
            12'h780: return m_idx[5];
            12'h781: return m_reg[5][m_idx[5]];
            12'h784: return m_misc;
            12'h7B4: return st;
            default: return 8'h00;
        endcase
    endfunction

    task automatic m_reset();
        for (int b = 0; b < NB; b++) begin
            m_idx[b] = 0;
            for (int i = 0; i < DEPTH; i++) m_reg[b][i] = 0;
        end
        m_ph = 0; m_misc = 0; m_rd = 0;
    endtask

    task automatic m_step(input bit w, input bit r, input logic [11:0] a,
                          input logic [7:0] d, input logic [7:0] st);
        if (r) begin
            m_rd = m_read(a, st);
            if (a == 12'h7B4) m_ph = 0;
        end
        if (w) begin
            for (int b = 0; b < 5; b++) begin
                if (a == pair_base[b])     m_idx[b] = d;
                if (a == pair_base[b] + 1) m_reg[b][m_idx[b]] = d;
            end
            if (a == 12'h780) begin
                if (!m_ph) m_idx[5] = d;
                else       m_reg[5][m_idx[5]] = d;
                m_ph = !m_ph;
            end
            if (a == 12'h784) m_misc = d;
        end
    endtask

    task automatic compare_all();
        logic [FLAT-1:0] exp_flat;
        for (int b = 0; b < NB; b++)
            for (int i = 0; i < DEPTH; i++)
                exp_flat[(b*DEPTH+i)*8 +: 8] = m_reg[b][i];
        check(host_rdata == m_rd, "R3 R10 rdata vs model", 32'(host_rdata), 32'(m_rd));
        check(misc_out == m_misc, "R8 misc_out vs model", 32'(misc_out), 32'(m_misc));
        check(video_en == m_idx[5][5], "R6 video_en vs model", 32'(video_en), 32'(m_idx[5][5]));
        check(regs_flat == exp_flat, "R2 R9 regs_flat vs model", 32'(regs_flat[31:0]), 32'(exp_flat[31:0]));
    endtask

    task automatic cyc(input bit w, input bit r, input logic [11:0] a, input logic [7:0] d);
        logic [7:0] st;
        st = status_in;
        host_wr = w; host_rd = r; host_addr = a; host_wdata = d;
        @(posedge clk);
        if (rst) m_reset(); else m_step(w, r, a, d, st);
        @(negedge clk);
        host_wr = 0; host_rd = 0;
        compare_all();
    endtask

    task automatic rd_expect(input logic [11:0] a, input logic [7:0] exp, input string tag);
        cyc(0, 1, a, 8'h00);
        check(host_rdata == exp, tag, 32'(host_rdata), 32'(exp));
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [11:0] pool [18];
        pool = '{12'h7AC, 12'h7AD, 12'h7A0, 12'h7A1, 12'h7A8, 12'h7A9, 12'h79C, 12'h79D,
                 12'h788, 12'h789, 12'h780, 12'h780, 12'h781, 12'h784, 12'h7B4, 12'h7B4,
                 12'h7FF, 12'h000};
        host_addr = 0; host_wdata = 0; host_wr = 0; host_rd = 0; status_in = 8'h5C;
        rst = 1;
        m_reset();
        @(negedge clk);
        cyc(0, 0, 0, 0);
        cyc(1, 1, 12'h7AD, 8'hFF);
        rst = 0;
        // R1: reset state
        check(host_rdata == 0, "R1 rdata after reset", 32'(host_rdata), 0);
        check(regs_flat == '0, "R1 registers after reset", 32'(regs_flat[31:0]), 0);
        check(misc_out == 0 && video_en == 0, "R1 misc/video after reset", {misc_out, 7'b0, video_en}, 0);

        // R2 R3: each paired bank gets its own index and value
        for (int b = 0; b < 5; b++) begin
            cyc(1, 0, pair_base[b], 8'(b * 37 + 5));
            cyc(1, 0, pair_base[b] + 1, 8'(8'hA0 + b));
        end
        for (int b = 0; b < 5; b++) begin
            rd_expect(pair_base[b], 8'(b * 37 + 5), "R3 index port readback");
            rd_expect(pair_base[b] + 1, 8'(8'hA0 + b), "R2 data port readback");
            check(regs_flat[(b*DEPTH + b*37 + 5)*8 +: 8] == 8'(8'hA0 + b), "R9 flat position",
                  32'(regs_flat[(b*DEPTH + b*37 + 5)*8 +: 8]), 32'(8'hA0 + b));
        end

        // R4 R6 R7: attribute alternation
        cyc(1, 0, 12'h780, 8'h25);
        check(video_en == 1, "R6 video_en set by index bit 5", 32'(video_en), 1);
        cyc(1, 0, 12'h780, 8'h5A);
        rd_expect(12'h781, 8'h5A, "R4 R7 attribute data readback");
        rd_expect(12'h780, 8'h25, "R7 attribute index readback");
        check(regs_flat[(5*DEPTH + 8'h25)*8 +: 8] == 8'h5A, "R9 attribute bank position",
              32'(regs_flat[(5*DEPTH + 8'h25)*8 +: 8]), 32'h5A);

        // R5: status read resets phase after a dangling index write
        cyc(1, 0, 12'h780, 8'h03);
        check(video_en == 0, "R6 video_en cleared", 32'(video_en), 0);
        status_in = 8'hC3;
        rd_expect(12'h7B4, 8'hC3, "R5 status value");
        cyc(1, 0, 12'h780, 8'h07);
        rd_expect(12'h780, 8'h07, "R5 phase reset to index");
        cyc(1, 0, 12'h780, 8'h33);
        rd_expect(12'h781, 8'h33, "R4 data phase after index");

        // R8
        cyc(1, 0, 12'h784, 8'hC7);
        check(misc_out == 8'hC7, "R8 misc_out", 32'(misc_out), 32'hC7);
        rd_expect(12'h784, 8'hC7, "R8 misc readback");

        // R10: ignored writes, zero reads
        cyc(1, 0, 12'h7FF, 8'h99);
        cyc(1, 0, 12'h7B4, 8'h99);
        cyc(1, 0, 12'h781, 8'h99);
        cyc(1, 0, 12'h000, 8'h99);
        rd_expect(12'h781, 8'h33, "R10 write to 0x781 ignored");
        rd_expect(12'h7FF, 8'h00, "R10 unmapped read");
        rd_expect(12'h7AD, 8'hA0, "R10 unmapped write left bank intact");

        // mixed random traffic against the model
        for (int k = 0; k < 4000; k++) begin
            int sel = $urandom_range(0, 17);
            int op  = $urandom_range(0, 2);
            status_in = 8'($urandom);
            cyc(op == 0, op == 1, pool[sel], 8'($urandom));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule